// File: doc/BRIEF.md
# Command-Driven Random Word Controller

This block is the register-level front end of a random number generator. A host controls it only by writing 32-bit command words to a single command offset. It observes progress through a one-byte status code and collects random data through a separate read offset. A free-running linear feedback shift register stands in for the entropy source.

Before any data flows, the host must walk the block through a fixed bring-up order: reset, release, enable, then zeroize. Zeroize starts a short startup health test, and the host must acknowledge its result. After that the block produces one word at a time. It signals that the word is ready, holds it until the host acknowledges the read, and starts the next word only when the host writes enable again. A test input freezes the source so that the failing health-test path can be exercised.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: A write with `wr_addr`=0 is a command. A read with `rd_addr`=0 returns the held random word, and `rd_addr`=4 returns the status byte in bits 7:0 with zeros above it. A read at any other offset returns 0, and a write at any other offset is ignored.
- R2: After `rst_n` is held low across a clock edge, status reads 0x00 and the held word reads 0.
- R3: The command 0x00000001 is accepted in every state. From the next cycle status reads 0xAC and the held word reads 0, and the block stays there until another valid command arrives.
- R4: Bring-up only advances in this order: 0x00000002 from the 0xAC state, then 0x80000000, then 0x80000004, which starts the health test. While this sequence is pending, a command that does not fit the current step is ignored and status reads 0x00 or 0xAC as before.
- R5: The health test takes TEST_WINDOW consecutive source samples. Status reads 0x57 exactly TEST_WINDOW+1 cycles after the zeroize command was accepted, provided no two consecutive samples were equal. If any two were equal, status reads 0xFA instead. Status reads 0x00 while the test runs.
- R6: While `force_stuck` is high, the source holds its value, so the health test reports 0xFA.
- R7: Status 0xFA is sticky. Every command except 0x00000001 leaves it unchanged.
- R8: From 0x57, the command 0x80000008 starts word generation. Status reads 0xED exactly GEN_CYCLES cycles after the command was accepted. The held word is the source value in the cycle before that status change.
- R9: While status reads 0xED, the held word is stable and nonzero, and every command other than 0x8000000F and 0x00000001 is ignored.
- R10: The command 0x8000000F moves status from 0xED to 0x00, and no new word appears on its own. A following 0x80000000 produces a new, different word after GEN_CYCLES cycles.
- R11: A command word that matches none of the six codes has no effect in any state.
- R12: The source is a 32-bit Fibonacci shift register. It loads SEED when `rst_n` is low. On every other cycle in which `force_stuck` is low, it shifts left, and the new bit 0 is the XOR of the state bits selected by the TAPS mask (default bits 31, 21, 1 and 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one command per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Command word |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| force_stuck | input | 1 | Test control that freezes the entropy source |

## Verification
The failing health test and its stickiness are the hardest to reach, because a working shift register never repeats a word. The bench holds `force_stuck` high through a complete bring-up and confirms that 0xFA appears on the same cycle a pass would have. It then sends every other command and checks that only the reset command clears the state. The data-available state only ever holds a live word, so the bench also sends each out-of-place command while a word is held. It checks that neither the status nor the word moves, and it compares every delivered word against its own model of the shift register.

// File: rtl/rng_ctrl_pkg.sv
// Shared command codes, status codes and lifecycle phases of the random
// word controller. Assumes 32-bit commands and one-byte status codes.
package rng_ctrl_pkg;
    localparam logic [31:0] CMD_RESET    = 32'h0000_0001;
    localparam logic [31:0] CMD_RELEASE  = 32'h0000_0002;
    localparam logic [31:0] CMD_ENABLE   = 32'h8000_0000;
    localparam logic [31:0] CMD_ZEROIZE  = 32'h8000_0004;
    localparam logic [31:0] CMD_ACK_ZERO = 32'h8000_0008;
    localparam logic [31:0] CMD_ACK_READ = 32'h8000_000F;

    localparam logic [7:0] STS_NONE    = 8'h00;
    localparam logic [7:0] STS_RST_ACK = 8'hAC;
    localparam logic [7:0] STS_PASS    = 8'h57;
    localparam logic [7:0] STS_FAIL    = 8'hFA;
    localparam logic [7:0] STS_AVAIL   = 8'hED;

    typedef enum logic [3:0] {
        PH_OFF, PH_RSTACK, PH_RELEASED, PH_ENABLED, PH_TEST,
        PH_PASS, PH_FAIL, PH_GEN, PH_AVAIL, PH_DRAINED
    } phase_t;
endpackage

// File: rtl/rng_lfsr_src.sv
// Stand-in entropy source: a Fibonacci shift register, shifting left, whose
// feedback is the XOR of the state bits selected by TAPS.
// Assumes TAPS describes a maximal-length polynomial and SEED is nonzero.
module rng_lfsr_src #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] SEED  = 32'hACE1_2468,
    parameter logic [31:0] TAPS  = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] state_q;
    logic             fb;

    // feedback bit from the tap mask
    always_comb fb = ^(state_q & TAPS[WIDTH-1:0]);

    // load the seed on reset, otherwise shift unless frozen
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= SEED[WIDTH-1:0];
        else if (!hold) state_q <= {state_q[WIDTH-2:0], fb};
    end

    assign value = state_q;

    a_r12_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_q != '0);
endmodule

// File: rtl/rng_health.sv
// Startup health test: while run is high, takes WINDOW samples and flags a
// failure if any two consecutive samples are equal. Clears itself whenever
// run is low. done stays high once the window has been taken.
module rng_health #(
    parameter int WIDTH  = 32,
    parameter int WINDOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [WIDTH-1:0] sample,
    output logic             done,
    output logic             fail
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] prev_q;
    logic             bad_q;

    // remember the previous sample for the repeat comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sample;
    end

    // count samples in the window and latch any repeat
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else if (cnt_q != CW'(WINDOW)) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q != '0 && sample == prev_q) bad_q <= 1'b1;
        end
    end

    assign done = (cnt_q == CW'(WINDOW));
    assign fail = bad_q;

    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WINDOW));
    a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0 && !bad_q);
endmodule

// File: rtl/rng_lifecycle.sv
// Lifecycle and operating state machine. Decodes command words, runs the
// bring-up order, waits for the health test, times word generation and
// holds the delivered word. The reset command wins over every other event.
module rng_lifecycle
    import rng_ctrl_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int GEN_CYCLES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [31:0]      cmd,
    input  logic             test_done,
    input  logic             test_fail,
    input  logic [WIDTH-1:0] src_word,
    output logic             test_run,
    output logic [7:0]       status,
    output logic [WIDTH-1:0] word
);
    localparam int GW = $clog2(GEN_CYCLES + 1);

    phase_t           ph_q, ph_d;
    logic [GW-1:0]    gcnt_q;
    logic [WIDTH-1:0] word_q;
    logic             is_rst;

    // reset command is honoured in any phase
    always_comb is_rst = cmd_vld && cmd == CMD_RESET;

    // next phase from current phase, command and test result
    always_comb begin
        ph_d = ph_q;
        if (is_rst) ph_d = PH_RSTACK;
        else begin
            case (ph_q)
                PH_RSTACK:   if (cmd_vld && cmd == CMD_RELEASE)  ph_d = PH_RELEASED;
                PH_RELEASED: if (cmd_vld && cmd == CMD_ENABLE)   ph_d = PH_ENABLED;
                PH_ENABLED:  if (cmd_vld && cmd == CMD_ZEROIZE)  ph_d = PH_TEST;
                PH_TEST:     if (test_done) ph_d = test_fail ? PH_FAIL : PH_PASS;
                PH_PASS:     if (cmd_vld && cmd == CMD_ACK_ZERO) ph_d = PH_GEN;
                PH_GEN:      if (gcnt_q == GW'(GEN_CYCLES - 1))   ph_d = PH_AVAIL;
                PH_AVAIL:    if (cmd_vld && cmd == CMD_ACK_READ) ph_d = PH_DRAINED;
                PH_DRAINED:  if (cmd_vld && cmd == CMD_ENABLE)   ph_d = PH_GEN;
                default:     ph_d = ph_q;
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_OFF;
        else        ph_q <= ph_d;
    end

    // generation timer, counts only while staying in the generate phase
    always_ff @(posedge clk) begin
        if (!rst_n)                               gcnt_q <= '0;
        else if (ph_q == PH_GEN && ph_d == PH_GEN) gcnt_q <= gcnt_q + 1'b1;
        else                                      gcnt_q <= '0;
    end

    // held word: cleared by reset, captured at the end of generation
    always_ff @(posedge clk) begin
        if (!rst_n || is_rst)                      word_q <= '0;
        else if (ph_q == PH_GEN && ph_d == PH_AVAIL) word_q <= src_word;
    end

    // status byte per phase
    always_comb begin
        case (ph_q)
            PH_RSTACK: status = STS_RST_ACK;
            PH_PASS:   status = STS_PASS;
            PH_FAIL:   status = STS_FAIL;
            PH_AVAIL:  status = STS_AVAIL;
            default:   status = STS_NONE;
        endcase
    end

    assign test_run = (ph_q == PH_TEST);
    assign word     = word_q;

    a_r3_reset_ack: assert property (@(posedge clk) disable iff (!rst_n)
        is_rst |=> status == STS_RST_ACK && word_q == '0);
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_FAIL && !is_rst |=> ph_q == PH_FAIL);
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_AVAIL && !is_rst && !(cmd_vld && cmd == CMD_ACK_READ)
        |=> ph_q == PH_AVAIL && $stable(word_q));
    a_r10_drained_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_DRAINED && !cmd_vld |=> ph_q == PH_DRAINED);
endmodule

// File: rtl/rng_cmd_ctrl.sv
// Top of the random word controller: address decode for the command write
// and the word/status reads, wiring of source, health test and lifecycle.
// Assumes byte offsets 0 and 4 fit in ADDR_W bits.
module rng_cmd_ctrl
    import rng_ctrl_pkg::*;
#(
    parameter int          ADDR_W      = 3,
    parameter int          GEN_CYCLES  = 32,
    parameter int          TEST_WINDOW = 16,
    parameter logic [31:0] SEED        = 32'hACE1_2468,
    parameter logic [31:0] TAPS        = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              force_stuck
);
    localparam int WIDTH = 32;

    logic [WIDTH-1:0] src_word, held_word;
    logic             cmd_vld, test_run, test_done, test_fail;
    logic [7:0]       status;

    // only writes at offset 0 are commands
    always_comb cmd_vld = wr_en && wr_addr == ADDR_W'(0);

    rng_lfsr_src #(.WIDTH(WIDTH), .SEED(SEED), .TAPS(TAPS)) u_src (
        .clk(clk), .rst_n(rst_n), .hold(force_stuck), .value(src_word)
    );

    rng_health #(.WIDTH(WIDTH), .WINDOW(TEST_WINDOW)) u_health (
        .clk(clk), .rst_n(rst_n), .run(test_run), .sample(src_word),
        .done(test_done), .fail(test_fail)
    );

    rng_lifecycle #(.WIDTH(WIDTH), .GEN_CYCLES(GEN_CYCLES)) u_life (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(wr_data),
        .test_done(test_done), .test_fail(test_fail), .src_word(src_word),
        .test_run(test_run), .status(status), .word(held_word)
    );

    // read decode: word at 0, status at 4, zero elsewhere
    always_comb begin
        if (rd_addr == ADDR_W'(0))      rd_data = held_word;
        else if (rd_addr == ADDR_W'(4)) rd_data = {24'h0, status};
        else                            rd_data = '0;
    end

    a_r9_avail_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        status == STS_AVAIL |-> held_word != '0);
    a_r1_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        status == STS_NONE || status == STS_RST_ACK || status == STS_PASS ||
        status == STS_FAIL || status == STS_AVAIL);
endmodule

// File: tb/test_rng_cmd_ctrl.sv
module test_rng_cmd_ctrl;
    localparam int GEN = 32;
    localparam int WIN = 16;
    localparam logic [31:0] SEED = 32'hACE1_2468;
    localparam logic [31:0] TAPS = 32'h8020_0003;

    localparam logic [31:0] C_RST = 32'h1, C_REL = 32'h2, C_EN = 32'h8000_0000;
    localparam logic [31:0] C_ZER = 32'h8000_0004, C_AZ = 32'h8000_0008;
    localparam logic [31:0] C_AR = 32'h8000_000F, C_BAD = 32'h1234_5678;

    logic        clk = 0, rst_n = 0, wr_en = 0, force_stuck = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 4;
    logic [31:0] wr_data = 0, rd_data;
    int checks = 0, failures = 0;
    logic [31:0] m, mp, cap_word, prev_word, rv;
    int n;

    always #10 clk = ~clk;

    rng_cmd_ctrl #(.GEN_CYCLES(GEN), .TEST_WINDOW(WIN), .SEED(SEED), .TAPS(TAPS))
    i_rng_cmd_ctrl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .force_stuck(force_stuck));

    // model of the source from R12
    always @(posedge clk) begin
        if (!rst_n) m <= SEED;
        else if (!force_stuck) begin
            mp <= m;
            m  <= {m[30:0], ^(m & TAPS)};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic status_is(input string req, input logic [31:0] exp);
        logic [31:0] d;
        rd(3'd4, d); chk(req, d, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // cycles until status leaves 0x00; captures model word at that point
    task automatic wait_nz(output int cnt);
        logic [31:0] d;
        cnt = 0;
        do begin
            @(negedge clk); cnt++;
            rd(3'd4, d);
        end while (d == 0 && cnt < 2000);
        cap_word = mp;
    endtask

    task automatic bring_up(input logic [31:0] exp_sts, input string req);
        wr(0, C_RST); wr(0, C_REL); wr(0, C_EN); wr(0, C_ZER);
        wait_nz(n);
        chk({req, " test latency"}, n, WIN + 1);
        status_is(req, exp_sts);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] bad_cmds [5];
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        status_is("R2 status", 0);
        rd(0, rv); chk("R2 word", rv, 0);
        rd(2, rv); chk("R1 other offset", rv, 0);
        // R4/R11 commands before reset command ignored
        wr(0, C_REL); wr(0, C_EN); wr(0, C_ZER); wr(0, C_AZ); wr(0, C_AR); wr(0, C_BAD);
        idle(WIN + 3);
        status_is("R4 ignored from off", 0);
        // R1 write at offset 4 ignored
        wr(4, C_RST); status_is("R1 write offset 4", 0);
        // R3 reset ack on next cycle
        wr(0, C_RST); status_is("R3 ack", 32'hAC);
        // R4/R11 sweep wrong commands in 0xAC phase
        bad_cmds = '{C_EN, C_ZER, C_AZ, C_AR, C_BAD};
        foreach (bad_cmds[i]) begin
            wr(0, bad_cmds[i]); status_is("R4 R11 in ack phase", 32'hAC);
        end
        wr(0, C_REL); status_is("R4 released", 0);
        wr(0, C_ZER); idle(WIN + 3);
        status_is("R4 zeroize before enable ignored", 0);
        wr(0, C_EN); wr(0, C_ZER);
        wait_nz(n);
        chk("R5 test latency", n, WIN + 1);
        status_is("R5 pass", 32'h57);
        foreach (bad_cmds[i]) if (bad_cmds[i] != C_AZ) begin
            wr(0, bad_cmds[i]); status_is("R11 in pass phase", 32'h57);
        end
        // R8 first word
        wr(0, C_AZ);
        wait_nz(n);
        chk("R8 gen latency", n, GEN);
        status_is("R8 avail", 32'hED);
        rd(0, rv); chk("R8 word matches source", rv, cap_word);
        prev_word = rv;
        // R9/R10 operating loop sweep
        for (int w = 0; w < 20; w++) begin
            wr(0, C_ZER); wr(0, C_EN); wr(0, C_AZ); wr(0, C_REL); wr(0, C_BAD);
            status_is("R9 ignored in avail", 32'hED);
            rd(0, rv); chk("R9 word stable", rv, prev_word);
            wr(0, C_AR); status_is("R10 ack read", 0);
            idle(GEN + 2); status_is("R10 no auto regen", 0);
            wr(0, C_EN);
            wait_nz(n);
            chk("R10 gen latency", n, GEN);
            rd(0, rv); chk("R10 word matches source", rv, cap_word);
            chk("R10 word differs", {31'b0, rv != prev_word}, 1);
            prev_word = rv;
        end
        // R3 reset while word held clears it
        wr(0, C_RST); status_is("R3 from avail", 32'hAC);
        rd(0, rv); chk("R3 word cleared", rv, 0);
        // R6/R7 stuck source and sticky failure
        force_stuck = 1;
        bring_up(32'hFA, "R6 stuck fails");
        force_stuck = 0;
        wr(0, C_AZ); wr(0, C_REL); wr(0, C_EN); wr(0, C_ZER); wr(0, C_AR); wr(0, C_BAD);
        idle(GEN + 2);
        status_is("R7 sticky", 32'hFA);
        wr(0, C_RST); status_is("R7 reset leaves fail", 32'hAC);
        bring_up(32'h57, "R5 pass after recovery");
        // R3 reset during generation
        wr(0, C_AZ); idle(5);
        wr(0, C_RST); idle(GEN + 2);
        status_is("R3 reset in gen", 32'hAC);
        rd(0, rv); chk("R3 word after gen reset", rv, 0);
        // R2 hardware reset mid-operation
        rst_n = 0; @(negedge clk); rst_n = 1;
        status_is("R2 hw reset", 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule